// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This unit returns a coarse approximation of the inverse square root of a 32-bit operand, good to about eight bits. It has two modes, chosen per operand by an input. In the floating mode the operand is an IEEE single-precision value. The unit sorts the operand into a class (NaN, zero, negative, infinity or ordinary) and produces the matching special result and exception flags. For an ordinary positive value it normalises the significand into one of two binades, reads an 8-bit estimate fraction from a table and computes the result exponent arithmetically.

In the unsigned mode the operand is an unsigned fraction in [0, 1) with the binary point above bit 31. The same table supplies a fixed-point estimate in [1, 2) whose integer bit sits at bit 31.

Operands arrive with a valid strobe and results leave one clock later through a single register stage. One operand can be accepted every cycle.

Top module: `rsqrt_est`

## Requirements
- R1: In floating mode, a NaN operand (exponent field 0xFF, nonzero fraction) gives 0x7FC00000. The invalid flag is set exactly when the operand was signalling, meaning fraction bit 22 is 0. Divide-by-zero stays low.
- R2: In floating mode, an operand whose exponent field is zero (true zero, or subnormal flushed to zero) gives an infinity of the same sign, {sign, 0xFF, 23'b0}, and raises divide-by-zero.
- R3: In floating mode, a negative operand that is not a NaN and whose exponent field is nonzero, negative infinity included, gives 0x7FC00000 and raises invalid.
- R4: In floating mode, +infinity (0x7F800000) gives 0x00000000 with both flags low.
- R5: In floating mode, a positive operand with exponent field e in 1..254 gives sign bit 0 and exponent field floor((380 − e)/2). Bits 14:0 are zero and both flags are low.
- R6: For R5 operands, result bits 22:15 equal round(256/√a) − 256. Here k is fraction bits 22:16. If e is odd (bit 23 = 1), a = (128 + k + 0.5)/512. If e is even, a = (128 + k + 0.5)/256.
- R7: In unsigned mode, an operand with bits 31:30 both zero gives 0xFFFFFFFF. The invalid and divide-by-zero flags are never raised in unsigned mode.
- R8: In unsigned mode, any other operand gives {1'b1, f, 23'b0}, where f = round(256/√a) − 256. If bit 31 is 1, a = (128 + bits 30:24 + 0.5)/256. If bits 31:30 are 01, a = (128 + bits 29:23 + 0.5)/512.
- R9: out_valid rises one cycle after an accepted operand and is low one cycle after a cycle without in_valid. While out_valid is low, the result and both flags are zero, including just after reset.
- R10: out_invalid and out_divzero are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_mode | input | 1 | 0 = single-precision float, 1 = unsigned fraction |
| in_operand | input | 32 | Operand bits |
| out_valid | output | 1 | Result present |
| out_result | output | 32 | Estimate or special value |
| out_invalid | output | 1 | Invalid-operation flag |
| out_divzero | output | 1 | Divide-by-zero flag |

## Verification
Every result and both flags belong to the operand presented on the previous rising edge. Nothing in the block spans more than that single register stage. The bench changes inputs on a falling edge and reads the outputs on the next falling edge, so exactly one rising edge separates stimulus and sample. It then updates the inputs at that same falling edge, which streams a fresh operand every cycle. One idle cycle at the end confirms that the valid strobe and the cleared result drop on the cycle after in_valid goes low.

// File: rtl/rsqrt_est_pkg.sv
package rsqrt_est_pkg;

    localparam int WORD_W    = 32;
    localparam int EXP_W     = 8;
    localparam int MAN_W     = 23;
    localparam int EXP_BIAS  = (1 << (EXP_W - 1)) - 1;
    // numerator of the halved result exponent: 3*bias - 1
    localparam int EXP_NUMER = 3 * EXP_BIAS - 1;
    localparam logic [WORD_W-1:0] DEFAULT_NAN = 32'h7FC0_0000;

    typedef enum logic [2:0] {
        CLS_NAN_QUIET,
        CLS_NAN_SIG,
        CLS_ZERO,
        CLS_NEG,
        CLS_INF_POS,
        CLS_NORMAL
    } opclass_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              invalid;
        logic              divzero;
    } rsq_out_t;

    // Estimate fraction for table entry i of one half.
    // The low half covers a in [0.25,0.5) and the high half a in [0.5,1).
    // It finds the largest s with (2s-1)^2 * m <= 2^sh, which equals round(2^est_w / sqrt(a)).
    function automatic int unsigned est_frac(input int unsigned est_w,
                                             input int unsigned idx_w,
                                             input int unsigned i,
                                             input bit          low_half);
        longint unsigned m;
        longint unsigned lim;
        longint unsigned s;
        longint unsigned cand;
        int unsigned     sh;
        m   = 2 * ((longint'(1) << idx_w) + i) + 1;
        sh  = 2 * est_w + idx_w + (low_half ? 5 : 4);
        lim = longint'(1) << sh;
        s   = longint'(1) << est_w;
        for (int b = int'(est_w) - 1; b >= 0; b--) begin
            cand = s | (longint'(1) << b);
            if ((2 * cand - 1) * (2 * cand - 1) * m <= lim)
                s = cand;
        end
        return int'(s - (longint'(1) << est_w));
    endfunction

endpackage

// File: rtl/rsqrt_est_classify.sv
module rsqrt_est_classify
    import rsqrt_est_pkg::*;
(
    input  logic [WORD_W-1:0] operand,
    output opclass_e          cls
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             sign_f;

    assign sign_f = operand[WORD_W-1];
    assign exp_f  = operand[WORD_W-2 -: EXP_W];
    assign man_f  = operand[MAN_W-1:0];

    always_comb begin
        if (&exp_f && (|man_f))
            cls = man_f[MAN_W-1] ? CLS_NAN_QUIET : CLS_NAN_SIG;
        else if (exp_f == '0)
            cls = CLS_ZERO;
        else if (sign_f)
            cls = CLS_NEG;
        else if (&exp_f)
            cls = CLS_INF_POS;
        else
            cls = CLS_NORMAL;
    end
endmodule

// File: rtl/rsqrt_est_select.sv
module rsqrt_est_select
    import rsqrt_est_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic                    mode_fix,
    input  logic [WORD_W-1:WORD_W-16] top_bits,
    output logic                    low_half,
    output logic [IDX_W-1:0]        idx
);
    // float: bit 23 is the exponent parity, fraction top bits follow
    // unsigned: leading one at bit 31 or bit 30 picks the half
    always_comb begin
        if (mode_fix) begin
            low_half = ~top_bits[WORD_W-1];
            idx      = top_bits[WORD_W-1] ? top_bits[WORD_W-2 -: IDX_W]
                                          : top_bits[WORD_W-3 -: IDX_W];
        end else begin
            low_half = top_bits[MAN_W];
            idx      = top_bits[MAN_W-1 -: IDX_W];
        end
    end
endmodule

// File: rtl/rsqrt_est_table.sv
module rsqrt_est_table
    import rsqrt_est_pkg::*;
#(
    parameter int EST_W = 8,
    parameter int IDX_W = 7
) (
    input  logic             low_half,
    input  logic [IDX_W-1:0] idx,
    output logic [EST_W-1:0] frac
);
    localparam int HALF  = 1 << IDX_W;
    localparam int DEPTH = 2 * HALF;

    logic [EST_W-1:0] rom [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        localparam bit IS_LOW = (gi < HALF);
        assign rom[gi] = EST_W'(est_frac(EST_W, IDX_W, gi % HALF, IS_LOW));
    end

    assign frac = rom[{~low_half, idx}];
endmodule

// File: rtl/rsqrt_est_pack.sv
module rsqrt_est_pack
    import rsqrt_est_pkg::*;
#(
    parameter int EST_W = 8
) (
    input  logic             mode_fix,
    input  opclass_e         cls,
    input  logic             sign_f,
    input  logic [EXP_W-1:0] exp_f,
    input  logic             fix_small,
    input  logic [EST_W-1:0] frac,
    output rsq_out_t         res
);
    localparam int XW = EXP_W + 2;
    localparam logic [XW-1:0] NUMER = XW'(EXP_NUMER);

    logic [XW-1:0]    diff;
    logic [EXP_W-1:0] res_exp;

    assign diff    = NUMER - {2'b00, exp_f};
    assign res_exp = diff[EXP_W:1];

    always_comb begin
        res = '0;
        if (mode_fix) begin
            res.value = fix_small ? '1
                                  : {1'b1, frac, {(WORD_W-1-EST_W){1'b0}}};
        end else begin
            unique case (cls)
                CLS_NAN_QUIET: res.value = DEFAULT_NAN;
                CLS_NAN_SIG: begin
                    res.value   = DEFAULT_NAN;
                    res.invalid = 1'b1;
                end
                CLS_ZERO: begin
                    res.value   = {sign_f, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
                    res.divzero = 1'b1;
                end
                CLS_NEG: begin
                    res.value   = DEFAULT_NAN;
                    res.invalid = 1'b1;
                end
                CLS_INF_POS: res.value = '0;
                default:
                    res.value = {1'b0, res_exp, frac, {(MAN_W-EST_W){1'b0}}};
            endcase
        end
    end
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
    import rsqrt_est_pkg::*;
#(
    parameter int EST_W = 8,
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [WORD_W-1:0] in_operand,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_invalid,
    output logic              out_divzero
);
    opclass_e         cls;
    logic             low_half;
    logic [IDX_W-1:0] idx;
    logic [EST_W-1:0] frac;
    rsq_out_t         res_d;
    rsq_out_t         res_q;
    logic             valid_q;

    rsqrt_est_classify u_classify (
        .operand (in_operand),
        .cls     (cls)
    );

    rsqrt_est_select #(.IDX_W(IDX_W)) u_select (
        .mode_fix (in_mode),
        .top_bits (in_operand[WORD_W-1:WORD_W-16]),
        .low_half (low_half),
        .idx      (idx)
    );

    rsqrt_est_table #(.EST_W(EST_W), .IDX_W(IDX_W)) u_table (
        .low_half (low_half),
        .idx      (idx),
        .frac     (frac)
    );

    rsqrt_est_pack #(.EST_W(EST_W)) u_pack (
        .mode_fix  (in_mode),
        .cls       (cls),
        .sign_f    (in_operand[WORD_W-1]),
        .exp_f     (in_operand[WORD_W-2 -: EXP_W]),
        .fix_small (in_operand[WORD_W-1:WORD_W-2] == 2'b00),
        .frac      (frac),
        .res       (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            res_q   <= in_valid ? res_d : '0;
        end
    end

    assign out_valid   = valid_q;
    assign out_result  = res_q.value;
    assign out_invalid = res_q.invalid;
    assign out_divzero = res_q.divzero;
endmodule

// File: rtl/rsqrt_est_checker.sv
module rsqrt_est_checker
    import rsqrt_est_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_mode,
    input logic [WORD_W-1:0] in_operand,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_result,
    input logic              out_invalid,
    input logic              out_divzero
);
    logic [EXP_W-1:0] e_in;
    logic             f_nz;
    logic             is_flt;

    assign e_in   = in_operand[WORD_W-2 -: EXP_W];
    assign f_nz   = |in_operand[MAN_W-1:0];
    assign is_flt = in_valid && !in_mode;

    assert_valid_on_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_off_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_result == '0 && !out_invalid && !out_divzero));

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(out_invalid && out_divzero));

    assert_unsigned_noflags_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode) |=> (!out_invalid && !out_divzero));

    assert_nan_R1: assert property (@(posedge clk) disable iff (rst)
        (is_flt && &e_in && f_nz) |=>
        (out_result == DEFAULT_NAN && out_invalid == !$past(in_operand[MAN_W-1])));

    assert_zero_inf_R2: assert property (@(posedge clk) disable iff (rst)
        (is_flt && e_in == '0) |=>
        (out_divzero && out_result == {$past(in_operand[WORD_W-1]), {EXP_W{1'b1}}, {MAN_W{1'b0}}}));

    assert_posinf_R4: assert property (@(posedge clk) disable iff (rst)
        (is_flt && in_operand == 32'h7F80_0000) |=>
        (out_result == '0 && !out_invalid && !out_divzero));

    assert_norm_shape_R5: assert property (@(posedge clk) disable iff (rst)
        (is_flt && !in_operand[WORD_W-1] && e_in != '0 && !(&e_in)) |=>
        (!out_result[WORD_W-1] && out_result[14:0] == '0 &&
         ({1'b0, out_result[WORD_W-2 -: EXP_W]} * 2 + {1'b0, $past(e_in)} >= 9'(EXP_NUMER - 1)) &&
         ({1'b0, out_result[WORD_W-2 -: EXP_W]} * 2 + {1'b0, $past(e_in)} <= 9'(EXP_NUMER))));
endmodule

bind rsqrt_est rsqrt_est_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_mode     (in_mode),
    .in_operand  (in_operand),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid),
    .out_divzero (out_divzero)
);

// File: tb/rsqrt_est_bench.sv
module rsqrt_est_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_mode;
    logic [31:0] in_operand;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;
    logic        out_divzero;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rsqrt_est u_rsqrt_est (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_mode     (in_mode),
        .in_operand  (in_operand),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid),
        .out_divzero (out_divzero)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h operand=%08h", tag, act, exp, in_operand);
        end
    endtask

    // real-valued model of the estimate fraction
    function automatic int ref_frac(input bit low, input int k);
        real a;
        int  s;
        a = low ? (128.0 + k + 0.5) / 512.0 : (128.0 + k + 0.5) / 256.0;
        s = int'($floor(256.0 / $sqrt(a) + 0.5));
        return s - 256;
    endfunction

    // called on a falling edge; returns on the next falling edge
    task automatic apply(input logic mode, input logic [31:0] op);
        in_valid   = 1'b1;
        in_mode    = mode;
        in_operand = op;
        @(negedge clk);
    endtask

    task automatic run_float(input logic [31:0] op);
        logic [31:0] exp_v;
        logic        exp_i;
        logic        exp_d;
        string       tag;
        logic [7:0]  e;
        e     = op[30:23];
        exp_i = 1'b0;
        exp_d = 1'b0;
        if (e == 8'hFF && op[22:0] != 0) begin
            tag = "R1"; exp_v = 32'h7FC0_0000; exp_i = !op[22];
        end else if (e == 8'h00) begin
            tag = "R2"; exp_v = {op[31], 8'hFF, 23'h0}; exp_d = 1'b1;
        end else if (op[31]) begin
            tag = "R3"; exp_v = 32'h7FC0_0000; exp_i = 1'b1;
        end else if (e == 8'hFF) begin
            tag = "R4"; exp_v = 32'h0;
        end else begin
            tag = "R5/R6";
            exp_v = {1'b0, 8'((380 - int'(e)) / 2),
                     8'(ref_frac(e[0], int'(op[22:16]))), 15'h0};
        end
        apply(1'b0, op);
        chk({tag, " result"}, out_result, exp_v);
        chk({tag, " invalid"}, {31'h0, out_invalid}, {31'h0, exp_i});
        chk({tag, " divzero"}, {31'h0, out_divzero}, {31'h0, exp_d});
        chk("R9 valid", {31'h0, out_valid}, 32'h1);
    endtask

    task automatic run_fixed(input logic [31:0] op);
        logic [31:0] exp_v;
        string       tag;
        if (op[31:30] == 2'b00) begin
            tag = "R7"; exp_v = 32'hFFFF_FFFF;
        end else begin
            tag = "R8";
            exp_v = {1'b1, 8'(ref_frac(!op[31], op[31] ? int'(op[30:24]) : int'(op[29:23]))), 23'h0};
        end
        apply(1'b1, op);
        chk({tag, " result"}, out_result, exp_v);
        chk("R7 invalid", {31'h0, out_invalid}, 32'h0);
        chk("R7 divzero", {31'h0, out_divzero}, 32'h0);
        chk("R9 valid", {31'h0, out_valid}, 32'h1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        in_valid   = 1'b0;
        in_mode    = 1'b0;
        in_operand = '0;
        repeat (3) @(negedge clk);
        // reset state (R9)
        chk("R9 reset valid", {31'h0, out_valid}, 32'h0);
        chk("R9 reset result", out_result, 32'h0);
        chk("R9 reset flags", {30'h0, out_invalid, out_divzero}, 32'h0);
        rst = 1'b0;

        // every exponent field, fraction and low bits varied (R1..R6)
        for (int e = 0; e < 256; e++)
            run_float({1'b0, 8'(e), 7'((e * 37 + 5) % 128), 16'((e * 977) ^ 16'h5A3C)});
        // exact zeros, subnormals, infinities (R2, R4, R3)
        run_float(32'h0000_0000);
        run_float(32'h8000_0000);
        run_float(32'h8000_0001);
        run_float(32'h007F_FFFF);
        run_float(32'h7F80_0000);
        run_float(32'hFF80_0000);
        // NaN flavours (R1)
        run_float(32'h7FC0_0000);
        run_float(32'h7F80_0001);
        run_float(32'hFFBF_FFFF);
        run_float(32'hFFC0_1234);
        // negatives (R3)
        run_float(32'hBF80_0000);
        run_float(32'h8080_0000);
        run_float(32'hC2F7_1000);
        // full table sweep, odd and even exponents (R6)
        for (int k = 0; k < 128; k++) begin
            run_float({1'b0, 8'd125, 7'(k), 16'(k * 301)});
            run_float({1'b0, 8'd126, 7'(k), 16'hFFFF - 16'(k)});
        end
        // exponent extremes (R5)
        run_float(32'h0080_0000);
        run_float(32'h7F7F_FFFF);
        // unsigned mode sweep (R7, R8)
        for (int k = 0; k < 128; k++) begin
            run_fixed({1'b1, 7'(k), 24'(k * 12345)});
            run_fixed({2'b01, 7'(k), 23'(k * 54321)});
        end
        run_fixed(32'h0000_0000);
        run_fixed(32'h3FFF_FFFF);
        run_fixed(32'h2000_0000);
        run_fixed(32'h4000_0000);
        run_fixed(32'hFFFF_FFFF);

        // idle cycle (R9)
        in_valid   = 1'b0;
        in_operand = 32'h0000_0000;
        @(negedge clk);
        chk("R9 idle valid", {31'h0, out_valid}, 32'h0);
        chk("R9 idle result", out_result, 32'h0);
        chk("R10 idle flags", {30'h0, out_invalid, out_divzero}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule